// File: doc/BRIEF.md
# NAND Flash Page-Program Command Target

This block is the device side of an 8-bit NAND flash command interface, cut down to the page-program path. Bus cycles reach it as single-clock write strobes. Two qualifier inputs mark each cycle as a command, an address or a data byte. A load command opens a page load. Data bytes then fill a page data register starting at a column pointer. A column-move command shifts that pointer without losing what was already loaded. A confirm command starts a timed internal program-and-verify against a small modelled page array, and a status command puts the I/O read path into status mode.

Programming is modelled as a bitwise AND of the data register into the page array. A test port can mark bits of one column as stuck at 1. Verify fails when a bit that was requested as 0 still reads 1 afterwards. A reset command aborts any load or program and holds the ready output low for a short fixed time.

Top module: `nand_prog_target`

## Requirements
- R1: Command 80h clears the data register to all FFh and resets the load state. It then takes five address cycles: the first is the column low byte, the second the column high byte, and the last three are ignored. Each following data byte is stored at the current column, and the column then advances by one.
- R2: Command 85h is accepted only during data input. It takes two address cycles (column low, then high) that set the column pointer. Bytes already in the register are kept.
- R3: Command 10h starts a program only when at least one data byte was written since the latest 80h and no program has started since then. Otherwise it is ignored, and `rdy` stays 1.
- R4: After an accepted 10h, `rdy` is 0 for exactly PROG_CYCLES clocks, starting with the clock that captured the command. While `rdy` is 0, only 70h and FFh are acted on. Other commands, address cycles and data cycles are ignored.
- R5: When the program completes, each array byte becomes old AND register, and stuck bits read 1. Status bit 0 is set when any bit loaded as 0 reads 1. Stuck bits loaded as 1 do not cause a failure.
- R6: After 70h, every read strobe returns status until another accepted command arrives. Reads outside status mode return FFh, and an ignored command leaves the mode unchanged.
- R7: The status byte has bit 6 = ready, bit 0 = fail and all other bits 0. After reset it reads 40h.
- R8: FFh, accepted even while busy, aborts any program without changing the array. It clears the fail flag, the register and the load state, and leaves status mode. It then holds `rdy` at 0 for exactly RST_CYCLES clocks.
- R9: Data bytes at columns of PAGE_BYTES or above are dropped. They are not stored and do not wrap to low columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-clock write strobe of a bus cycle |
| cmd_latch | input | 1 | Qualifies the write cycle as a command |
| addr_latch | input | 1 | Qualifies the write cycle as an address |
| io_in | input | 8 | Command, address or data byte |
| rd_stb | input | 1 | One-clock read strobe |
| io_out | output | 8 | Read data, registered on `rd_stb` |
| rdy | output | 1 | 1 when idle, 0 while programming or resetting |
| stuck_col | input | 6 | Column that holds the stuck cells (test) |
| stuck_bits | input | 8 | Bits of that column stuck at 1 (test) |

## Verification
The hardest situation to reach is a verify failure, because the AND model can never fail by itself. The bench creates it by marking a column bit as stuck and then loading a 0 into that bit along several different paths: by consecutive column advance, by an 85h pointer move, and by a byte kept across a later 85h. It also checks that a later 80h discards such a byte and that an out-of-range write does not wrap onto the stuck column. An aborted program is reached by issuing FFh in the middle of a busy period whose completion would have reported a failure.

// File: rtl/nand_tgt_pkg.sv
// Shared command codes and decoder phases for the NAND program target.
package nand_tgt_pkg;
    localparam logic [7:0] CMD_LOAD    = 8'h80;
    localparam logic [7:0] CMD_MOVE    = 8'h85;
    localparam logic [7:0] CMD_CONFIRM = 8'h10;
    localparam logic [7:0] CMD_STATUS  = 8'h70;
    localparam logic [7:0] CMD_RESET   = 8'hFF;
    localparam logic [2:0] ADDR_FULL   = 3'd5;
    localparam logic [2:0] ADDR_COLONLY = 3'd2;

    typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA} phase_t;
endpackage

// File: rtl/nand_bus_decoder.sv
// Decodes write bus cycles into load, column, data, start and reset events.
// Assumes at most one write strobe per clock; tracks address-cycle count
// and the sticky status-read mode. While busy only status/reset act.
module nand_bus_decoder
    import nand_tgt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_stb,
    input  logic        cmd_latch,
    input  logic        addr_latch,
    input  logic [7:0]  io_in,
    input  logic        busy,
    input  logic        loaded,
    output logic        ev_clear,
    output logic        ev_col,
    output logic [15:0] col_val,
    output logic        ev_data,
    output logic [7:0]  data_val,
    output logic        ev_start,
    output logic        ev_reset,
    output logic        status_mode
);
    phase_t      phase;
    logic [2:0]  acnt;
    logic [2:0]  need;
    logic [7:0]  col_lo;
    logic        is_cmd, is_addr, is_data, move_ok, stat_cmd;

    // Classify the current bus cycle and form the events.
    always_comb begin
        is_cmd   = wr_stb && cmd_latch && !addr_latch;
        is_addr  = wr_stb && addr_latch && !cmd_latch;
        is_data  = wr_stb && !cmd_latch && !addr_latch;
        ev_reset = is_cmd && (io_in == CMD_RESET);
        stat_cmd = is_cmd && (io_in == CMD_STATUS);
        ev_clear = is_cmd && !busy && (io_in == CMD_LOAD);
        move_ok  = is_cmd && !busy && (io_in == CMD_MOVE) && (phase == PH_DATA);
        ev_start = is_cmd && !busy && (io_in == CMD_CONFIRM) && (phase == PH_DATA) && loaded;
        ev_col   = is_addr && !busy && (phase == PH_ADDR) && (acnt == 3'd1);
        col_val  = {io_in, col_lo};
        ev_data  = is_data && !busy && (phase == PH_DATA);
        data_val = io_in;
    end

    // Phase, address counting and status-mode state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            acnt        <= '0;
            need        <= '0;
            col_lo      <= '0;
            status_mode <= 1'b0;
        end else if (ev_reset) begin
            phase       <= PH_IDLE;
            acnt        <= '0;
            status_mode <= 1'b0;
        end else if (ev_clear) begin
            phase       <= PH_ADDR;
            acnt        <= '0;
            need        <= ADDR_FULL;
            status_mode <= 1'b0;
        end else if (move_ok) begin
            phase       <= PH_ADDR;
            acnt        <= '0;
            need        <= ADDR_COLONLY;
            status_mode <= 1'b0;
        end else if (ev_start) begin
            phase       <= PH_IDLE;
            status_mode <= 1'b0;
        end else if (stat_cmd) begin
            status_mode <= 1'b1;
        end else if (is_addr && !busy && phase == PH_ADDR) begin
            if (acnt == 3'd0) col_lo <= io_in;
            if (acnt == need - 3'd1) phase <= PH_DATA;
            acnt <= acnt + 3'd1;
        end
    end

    // R6: status mode persists while no bus write arrives.
    a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        status_mode && !wr_stb |=> status_mode);
    // R4: nothing but status/reset gets through while busy.
    a_r4_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(ev_clear || ev_col || ev_data || ev_start));
endmodule

// File: rtl/nand_page_reg.sv
// Page data register with a movable column pointer.
// Assumes events arrive one per clock from the decoder; bytes at columns
// beyond the page are dropped; the register reads FFh where unloaded.
module nand_page_reg #(
    parameter int PAGE_BYTES = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ev_clear,
    input  logic                    ev_reset,
    input  logic                    ev_col,
    input  logic [15:0]             col_val,
    input  logic                    ev_data,
    input  logic [7:0]              data_val,
    input  logic                    ev_start,
    output logic [PAGE_BYTES*8-1:0] page_bits,
    output logic                    loaded
);
    localparam int COL_W = $clog2(PAGE_BYTES);
    logic [15:0] ptr;

    // Register contents, column pointer and loaded flag.
    always_ff @(posedge clk) begin
        if (!rst_n || ev_clear || ev_reset) begin
            page_bits <= '1;
            ptr       <= '0;
            loaded    <= 1'b0;
        end else if (ev_col) begin
            ptr <= col_val;
        end else if (ev_data) begin
            if (ptr < 16'(PAGE_BYTES))
                page_bits[ptr[COL_W-1:0]*8 +: 8] <= data_val;
            if (ptr != 16'hFFFF) ptr <= ptr + 16'd1;
            loaded <= 1'b1;
        end else if (ev_start) begin
            loaded <= 1'b0;
        end
    end

    // R1: a load command empties the register and rewinds the pointer.
    a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        ev_clear |=> !loaded && ptr == 16'd0);
    // R3: a program only starts with data loaded.
    a_r3_start_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |-> loaded);
endmodule

// File: rtl/nand_prog_engine.sv
// Timed program-and-verify engine over a modelled page array.
// Assumes start is only raised when idle; the array update and verify
// happen on the last busy clock; a reset aborts without any update.
module nand_prog_engine #(
    parameter int PAGE_BYTES  = 64,
    parameter int PROG_CYCLES = 40,
    parameter int RST_CYCLES  = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ev_start,
    input  logic                        ev_reset,
    input  logic [PAGE_BYTES*8-1:0]     page_bits,
    input  logic [$clog2(PAGE_BYTES)-1:0] stuck_col,
    input  logic [7:0]                  stuck_bits,
    output logic                        busy,
    output logic                        fail
);
    localparam int MAXC  = (PROG_CYCLES > RST_CYCLES) ? PROG_CYCLES : RST_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);

    logic [PAGE_BYTES*8-1:0] arr, arr_next;
    logic [PAGE_BYTES-1:0]   bad;
    logic [CNT_W-1:0]        cnt;
    logic                    prog_mode, finish;

    // Per-byte programmed value and verify mismatch.
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
        logic [7:0] nb;
        always_comb begin
            nb  = (arr[g*8 +: 8] & page_bits[g*8 +: 8])
                | ((stuck_col == g[$clog2(PAGE_BYTES)-1:0]) ? stuck_bits : 8'h00);
            arr_next[g*8 +: 8] = nb;
            bad[g] = |(~page_bits[g*8 +: 8] & nb);
        end
    end

    assign finish = busy && (cnt == CNT_W'(1)) && !ev_reset;

    // Busy timer, array update and fail flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr       <= '1;
            busy      <= 1'b0;
            prog_mode <= 1'b0;
            cnt       <= '0;
            fail      <= 1'b0;
        end else if (ev_reset) begin
            busy      <= 1'b1;
            prog_mode <= 1'b0;
            cnt       <= CNT_W'(RST_CYCLES);
            fail      <= 1'b0;
        end else if (ev_start && !busy) begin
            busy      <= 1'b1;
            prog_mode <= 1'b1;
            cnt       <= CNT_W'(PROG_CYCLES);
        end else if (finish) begin
            busy <= 1'b0;
            if (prog_mode) begin
                arr  <= arr_next;
                fail <= |bad;
            end
        end else if (busy) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // R4: busy persists until its count runs out.
    a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cnt != CNT_W'(1) && !ev_reset |=> busy);
    // R5: with no stuck cells a completed program passes.
    a_r5_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
        finish && prog_mode && stuck_bits == 8'h00 |=> !fail);
    // R8: reset clears the fail flag and enters busy.
    a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ev_reset |=> busy && !fail);
endmodule

// File: rtl/nand_prog_target.sv
// Top of the NAND page-program command target.
// Assumes strobes are synchronous single-clock pulses; io_out is the
// registered read value (status in status mode, else FFh).
module nand_prog_target #(
    parameter int PAGE_BYTES  = 64,
    parameter int PROG_CYCLES = 40,
    parameter int RST_CYCLES  = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_stb,
    input  logic                          cmd_latch,
    input  logic                          addr_latch,
    input  logic [7:0]                    io_in,
    input  logic                          rd_stb,
    output logic [7:0]                    io_out,
    output logic                          rdy,
    input  logic [$clog2(PAGE_BYTES)-1:0] stuck_col,
    input  logic [7:0]                    stuck_bits
);
    logic        ev_clear, ev_col, ev_data, ev_start, ev_reset;
    logic        status_mode, busy, fail, loaded;
    logic [15:0] col_val;
    logic [7:0]  data_val;
    logic [PAGE_BYTES*8-1:0] page_bits;

    nand_bus_decoder u_dec (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cmd_latch(cmd_latch),
        .addr_latch(addr_latch), .io_in(io_in), .busy(busy), .loaded(loaded),
        .ev_clear(ev_clear), .ev_col(ev_col), .col_val(col_val),
        .ev_data(ev_data), .data_val(data_val), .ev_start(ev_start),
        .ev_reset(ev_reset), .status_mode(status_mode)
    );

    nand_page_reg #(.PAGE_BYTES(PAGE_BYTES)) u_reg (
        .clk(clk), .rst_n(rst_n), .ev_clear(ev_clear), .ev_reset(ev_reset),
        .ev_col(ev_col), .col_val(col_val), .ev_data(ev_data),
        .data_val(data_val), .ev_start(ev_start), .page_bits(page_bits),
        .loaded(loaded)
    );

    nand_prog_engine #(.PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES),
                       .RST_CYCLES(RST_CYCLES)) u_eng (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_reset(ev_reset),
        .page_bits(page_bits), .stuck_col(stuck_col), .stuck_bits(stuck_bits),
        .busy(busy), .fail(fail)
    );

    assign rdy = !busy;

    // Registered read path: status byte or FFh.
    always_ff @(posedge clk) begin
        if (!rst_n)      io_out <= 8'hFF;
        else if (rd_stb) io_out <= status_mode ? {1'b0, !busy, 5'b0, fail} : 8'hFF;
    end
endmodule

// File: tb/nand_prog_target_tb.sv
`timescale 1ns/1ps
module nand_prog_target_tb;
    localparam int PB = 64, PC = 40, RC = 6;
    logic clk = 0, rst_n = 0, wr_stb = 0, cmd_latch = 0, addr_latch = 0, rd_stb = 0;
    logic [7:0] io_in = 0, io_out, stuck_bits = 8'h04;
    logic [5:0] stuck_col = 6'd3;
    logic rdy, mon_arm = 0;
    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    nand_prog_target #(.PAGE_BYTES(PB), .PROG_CYCLES(PC), .RST_CYCLES(RC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cmd_latch(cmd_latch),
        .addr_latch(addr_latch), .io_in(io_in), .rd_stb(rd_stb), .io_out(io_out),
        .rdy(rdy), .stuck_col(stuck_col), .stuck_bits(stuck_bits));

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each read result against the scoreboard queue.
    always @(posedge clk) mon_arm <= rd_stb;
    always @(negedge clk) if (mon_arm) begin
        if (exp_q.size() == 0) chk(8'hEE, 8'h00, "scoreboard underflow");
        else chk(io_out, exp_q.pop_front(), tag_q.pop_front());
    end

    task automatic wr(input logic c, input logic a, input logic [7:0] d);
        @(negedge clk); cmd_latch = c; addr_latch = a; io_in = d; wr_stb = 1;
        @(negedge clk); wr_stb = 0; cmd_latch = 0; addr_latch = 0;
    endtask
    task automatic cmd(input logic [7:0] c); wr(1, 0, c); endtask
    task automatic dat(input logic [7:0] d); wr(0, 0, d); endtask
    task automatic load(input logic [15:0] col);
        cmd(8'h80); wr(0, 1, col[7:0]); wr(0, 1, col[15:8]);
        wr(0, 1, 8'h00); wr(0, 1, 8'h00); wr(0, 1, 8'h00);
    endtask
    task automatic move(input logic [15:0] col);
        cmd(8'h85); wr(0, 1, col[7:0]); wr(0, 1, col[15:8]);
    endtask
    task automatic rd(input logic [7:0] exp, input string tag);
        @(negedge clk); rd_stb = 1; exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); rd_stb = 0;
    endtask
    task automatic wait_rdy(output int n);
        n = 0;
        while (!rdy) begin n++; @(negedge clk); end
    endtask
    task automatic run_prog(input logic [7:0] exp, input string tag);
        int n;
        cmd(8'h10); wait_rdy(n); cmd(8'h70); rd(exp, tag);
    endtask

    initial begin
        #(4 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
        chk({7'b0, rdy}, 8'h01, "R7 ready after reset");
        rd(8'hFF, "R6 read outside status mode");
        cmd(8'h70); rd(8'h40, "R7 reset status"); rd(8'h40, "R6 sticky second read");
        // R3: bare confirm, and confirm with address but no data
        cmd(8'h10); chk({7'b0, rdy}, 8'h01, "R3 bare confirm ignored");
        rd(8'h40, "R6 ignored command keeps status mode");
        load(16'd0); cmd(8'h10); chk({7'b0, rdy}, 8'h01, "R3 confirm without data ignored");
        // R4 busy length, R5 pass with stuck bit requested 1
        load(16'd0); dat(8'h00); dat(8'h00); dat(8'h00); dat(8'hFF);
        cmd(8'h10); wait_rdy(n); chk(8'(n), 8'(PC), "R4 program busy length");
        cmd(8'h70); rd(8'h40, "R5 pass");
        // R1 consecutive columns reach stuck col 3; R4 busy status and ignored load
        load(16'd2); dat(8'hFF); dat(8'h00); cmd(8'h10);
        cmd(8'h70); rd(8'h00, "R4 status while busy");
        load(16'd9); rd(8'h00, "R4 load ignored while busy");
        wait_rdy(n); rd(8'h41, "R1 consecutive column fail");
        // R1 new load discards earlier bytes
        load(16'd3); dat(8'h00); load(16'd5); dat(8'h00);
        run_prog(8'h40, "R1 load discards previous data");
        // R2 move pointer
        load(16'd0); dat(8'hFF); move(16'd3); dat(8'hFB);
        run_prog(8'h41, "R2 moved pointer fail");
        load(16'd3); dat(8'h00); move(16'd10); dat(8'h5A);
        run_prog(8'h41, "R2 moved keeps data");
        // R5 stuck bit loaded as 1 passes
        load(16'd3); dat(8'h04); run_prog(8'h40, "R5 stuck bit requested 1");
        // R9 overflow does not wrap
        stuck_col = 6'd0; stuck_bits = 8'h01;
        load(16'(PB - 1)); dat(8'hFF); dat(8'h00);
        run_prog(8'h40, "R9 overflow dropped");
        stuck_col = 6'd3; stuck_bits = 8'h04;
        // R8 reset aborts a failing program
        load(16'd3); dat(8'h00); run_prog(8'h41, "R5 fail before abort");
        load(16'd3); dat(8'h00); cmd(8'h10); cmd(8'hFF);
        wait_rdy(n); chk(8'(n), 8'(RC), "R8 reset busy length");
        rd(8'hFF, "R8 status mode exited");
        cmd(8'h70); rd(8'h40, "R8 abort and fail cleared");
        cmd(8'h10); chk({7'b0, rdy}, 8'h01, "R8 load state cleared");
        repeat (3) @(negedge clk);
        chk(8'(exp_q.size()), 8'h00, "scoreboard drained");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule